// File: doc/BRIEF.md
# Filtered Quadrature Encoder Counter

This block turns the raw lines of one incremental encoder into a position count. The A, B, Index and Index-Mask lines come from off chip. They pass through a synchronizer, and A, B and Index then pass through a glitch filter whose acceptance length is selectable. The filtered A and B are decoded either as a quadrature pair at four counts per cycle or as a step line (A) with a direction line (B). Each accepted step moves two 32-bit counters together: a working count that the controller may zero, and a raw count that nothing but the reset pin clears.

The working count can also be zeroed by an index event. A rising edge on the index request input arms a one-shot capture. The next Index edge of the selected polarity then zeroes the count and clears the armed flag, which tells the controller that the event has happened. That edge may also be gated by the Index-Mask line. There are no data streams and so no valid/ready handshake and no back-pressure. The counts are free-running outputs that can be sampled at any time, and every control pin is a plain level.

Top module: `qenc_counter`

## Requirements
- R1: With `filt_long_i`=1, a level change on A, B or Index that is held for 15 consecutive clocks is accepted, and one that is held for 14 clocks is discarded.
- R2: With `filt_long_i`=0, the acceptance length is 3 clocks, and a change that is held for 2 clocks is discarded.
- R3: With `step_dir_i`=0, the filtered pair {A,B} is decoded at four counts per cycle. The forward order 00→10→11→01→00 adds one per transition, and the reverse order subtracts one.
- R4: In quadrature mode, a simultaneous change of both filtered A and B leaves both counts unchanged and sets `quad_err_o`. The flag stays set until `rst_ni` is asserted.
- R5: With `step_dir_i`=1, each rising edge of filtered A adds one when filtered B is 1 and subtracts one when it is 0. A change on B alone does not count.
- R6: The index event is taken on a rising edge of filtered Index when `idx_rise_i`=1, and on a falling edge when it is 0.
- R7: With `mask_en_i`=1, an index edge is qualified only while the synchronized Index-Mask line is 1 (`mask_low_i`=0) or 0 (`mask_low_i`=1).
- R8: A 0→1 change of `idx_req_i` sets `idx_armed_o`. The first qualified index event while armed zeroes `count_o` and clears `idx_armed_o`. Holding `idx_req_i` high does not arm the block again.
- R9: While `cnt_clr_i` is high, `count_o` reads zero from the clock after it rises, and steps do not move it.
- R10: `raw_o` follows every accepted step and is not changed by `cnt_clr_i` or by the index clear.
- R11: After `rst_ni` is released, `count_o`, `raw_o`, `idx_armed_o` and `quad_err_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_a_i | input | 1 | Encoder A (step in step/dir mode), asynchronous |
| enc_b_i | input | 1 | Encoder B (direction in step/dir mode), asynchronous |
| enc_idx_i | input | 1 | Encoder Index, asynchronous |
| enc_mask_i | input | 1 | Index-Mask line, asynchronous |
| filt_long_i | input | 1 | 1: 15-clock filter, 0: 3-clock filter |
| step_dir_i | input | 1 | 0: quadrature, 1: step/direction |
| idx_rise_i | input | 1 | Index edge select, 1 rising, 0 falling |
| mask_en_i | input | 1 | Gate index edges with Index-Mask |
| mask_low_i | input | 1 | Index-Mask active level is low |
| cnt_clr_i | input | 1 | Hold the working count at zero |
| idx_req_i | input | 1 | Rising edge arms the index clear |
| count_o | output | 32 | Working count, two's complement |
| raw_o | output | 32 | Raw count, two's complement |
| idx_armed_o | output | 1 | Index clear armed; falls when the clear happens |
| quad_err_o | output | 1 | Sticky illegal-transition flag |

## Verification
The assertions check four things on every clock. The raw count moves by at most one. The working count moves by the same amount as the raw count except when it is cleared. A fall of the armed flag always comes with a zero count. The armed flag rises only after a request. The assertions also check that the error flag is sticky and that a held clear keeps the count at zero. The filter length boundaries, the quadrature direction order, the step/direction rules, the index polarity and mask qualification, and the one-shot re-arm rule can only be shown by the bench scenarios. Those scenarios compare both counts against a bench model after random step walks and glitches, and after directed index and mask sequences.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic {
    MODE_QUAD    = 1'b0,
    MODE_STEPDIR = 1'b1
  } qenc_mode_e;

  // Position of an {a,b} pair in the forward cycle 00,10,11,01
  function automatic logic [1:0] quad_phase(input logic a, input logic b);
    return {b, a ^ b};
  endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q[0] <= '0;
    else         st_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[s] <= '0;
      else         st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/qenc_glitch_filter.sv
module qenc_glitch_filter #(
  parameter int LONG  = 15,
  parameter int SHORT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic long_i,
  input  logic raw_i,
  output logic filt_o
);

  localparam int CW = $clog2(LONG + 1);
  localparam logic [CW-1:0] LIM_LONG  = CW'(LONG - 1);
  localparam logic [CW-1:0] LIM_SHORT = CW'(SHORT - 1);

  logic [CW-1:0] run_q;
  logic [CW-1:0] lim;
  logic          filt_q;

  always_comb lim = long_i ? LIM_LONG : LIM_SHORT;

  // run_q counts consecutive samples that disagree with the filtered level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      filt_q <= 1'b0;
    end else if (raw_i == filt_q) begin
      run_q <= '0;
    end else if (run_q >= lim) begin
      filt_q <= raw_i;
      run_q  <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

endmodule

// File: rtl/qenc_motion_dec.sv
module qenc_motion_dec
  import qenc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  qenc_mode_e mode_i,
  input  logic       a_i,
  input  logic       b_i,
  output logic       inc_o,
  output logic       dec_o,
  output logic       bad_o
);

  logic       a_q, b_q;
  logic [1:0] diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  always_comb diff = quad_phase(a_i, b_i) - quad_phase(a_q, b_q);

  always_comb begin
    inc_o = 1'b0;
    dec_o = 1'b0;
    bad_o = 1'b0;
    if (mode_i == MODE_STEPDIR) begin
      if (a_i && !a_q) begin
        inc_o = b_i;
        dec_o = !b_i;
      end
    end else begin
      unique case (diff)
        2'd1:    inc_o = 1'b1;
        2'd3:    dec_o = 1'b1;
        2'd2:    bad_o = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/qenc_index_qual.sv
module qenc_index_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idx_i,
  input  logic mask_i,
  input  logic rise_i,
  input  logic mask_en_i,
  input  logic mask_low_i,
  output logic evt_o
);

  logic idx_q;
  logic edge_hit;
  logic mask_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= 1'b0;
    else         idx_q <= idx_i;
  end

  always_comb begin
    edge_hit = rise_i ? (idx_i && !idx_q) : (!idx_i && idx_q);
    mask_ok  = !mask_en_i || (mask_i ^ mask_low_i);
    evt_o    = edge_hit && mask_ok;
  end

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int FILT_LONG   = 15,
  parameter int FILT_SHORT  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enc_a_i,
  input  logic             enc_b_i,
  input  logic             enc_idx_i,
  input  logic             enc_mask_i,
  input  logic             filt_long_i,
  input  logic             step_dir_i,
  input  logic             idx_rise_i,
  input  logic             mask_en_i,
  input  logic             mask_low_i,
  input  logic             cnt_clr_i,
  input  logic             idx_req_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] raw_o,
  output logic             idx_armed_o,
  output logic             quad_err_o
);

  localparam int N_FILT = 3;          // A, B, Index
  localparam int N_SYNC = N_FILT + 1; // plus Index-Mask

  logic [N_SYNC-1:0] pins_s;
  logic [N_FILT-1:0] pins_f;
  logic              step_inc, step_dec, step_bad;
  logic              idx_evt, idx_hit;
  logic              req_q, armed_q, err_q;
  logic [CNT_W-1:0]  count_q, raw_q;

  qenc_sync #(.W(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({enc_mask_i, enc_idx_i, enc_b_i, enc_a_i}),
    .q_o    (pins_s)
  );

  for (genvar c = 0; c < N_FILT; c++) begin : g_filt
    qenc_glitch_filter #(.LONG(FILT_LONG), .SHORT(FILT_SHORT)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .long_i (filt_long_i),
      .raw_i  (pins_s[c]),
      .filt_o (pins_f[c])
    );
  end

  qenc_motion_dec u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (step_dir_i ? MODE_STEPDIR : MODE_QUAD),
    .a_i    (pins_f[0]),
    .b_i    (pins_f[1]),
    .inc_o  (step_inc),
    .dec_o  (step_dec),
    .bad_o  (step_bad)
  );

  qenc_index_qual u_idx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_i      (pins_f[2]),
    .mask_i     (pins_s[3]),
    .rise_i     (idx_rise_i),
    .mask_en_i  (mask_en_i),
    .mask_low_i (mask_low_i),
    .evt_o      (idx_evt)
  );

  assign idx_hit = armed_q && idx_evt;

  // One-shot arming: only a fresh request edge sets the flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      req_q <= idx_req_i;
      if (idx_hit)                    armed_q <= 1'b0;
      else if (idx_req_i && !req_q)   armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      raw_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      if (step_bad) err_q <= 1'b1;
      if (step_inc)      raw_q <= raw_q + 1'b1;
      else if (step_dec) raw_q <= raw_q - 1'b1;
      if (cnt_clr_i || idx_hit) count_q <= '0;
      else if (step_inc)        count_q <= count_q + 1'b1;
      else if (step_dec)        count_q <= count_q - 1'b1;
    end
  end

  assign count_o     = count_q;
  assign raw_o       = raw_q;
  assign idx_armed_o = armed_q;
  assign quad_err_o  = err_q;

endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_clr_i,
  input logic             idx_req_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] raw_o,
  input logic             idx_armed_o,
  input logic             quad_err_o
);

  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] M_ONE = '1;

  // R10: the raw count moves by at most one step per clock
  a_r10_raw_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_o - $past(raw_o)) == '0) || ((raw_o - $past(raw_o)) == ONE) ||
    ((raw_o - $past(raw_o)) == M_ONE));

  // R10: working and raw counts move together unless a clear happened
  a_r10_counts_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cnt_clr_i) && !$fell(idx_armed_o)) |->
    ((count_o - $past(count_o)) == (raw_o - $past(raw_o))));

  // R9: a clear seen on the previous clock leaves the count at zero
  a_r9_clear_zeroes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cnt_clr_i) |-> (count_o == '0));

  // R8: the armed flag drops only together with a zeroed count
  a_r8_ack_with_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(idx_armed_o) |-> (count_o == '0));

  // R8: arming needs a request
  a_r8_arm_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idx_armed_o) |-> $past(idx_req_i));

  // R4: the error flag is sticky
  a_r4_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(quad_err_o) |-> quad_err_o);

endmodule

bind qenc_counter qenc_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cnt_clr_i   (cnt_clr_i),
  .idx_req_i   (idx_req_i),
  .count_o     (count_o),
  .raw_o       (raw_o),
  .idx_armed_o (idx_armed_o),
  .quad_err_o  (quad_err_o)
);

// File: tb/qenc_counter_tb_top.sv
module qenc_counter_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        enc_a, enc_b, enc_idx, enc_mask;
  logic        filt_long, step_dir, idx_rise, mask_en, mask_low, cnt_clr, idx_req;
  logic [31:0] count, raw;
  logic        armed, qerr;

  qenc_counter dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .enc_a_i(enc_a), .enc_b_i(enc_b), .enc_idx_i(enc_idx), .enc_mask_i(enc_mask),
    .filt_long_i(filt_long), .step_dir_i(step_dir), .idx_rise_i(idx_rise),
    .mask_en_i(mask_en), .mask_low_i(mask_low), .cnt_clr_i(cnt_clr),
    .idx_req_i(idx_req),
    .count_o(count), .raw_o(raw), .idx_armed_o(armed), .quad_err_o(qerr)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [31:0] exp_cnt = '0;
  logic [31:0] exp_raw = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int thr_of(input logic lng);
    return lng ? 15 : 3;
  endfunction

  // Forward order 00,10,11,01 on {A,B}
  function automatic int pos_of(input logic a, input logic b);
    case ({a, b})
      2'b00:   return 0;
      2'b10:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [1:0] ab_of(input int p);
    case (p & 3)
      0:       return 2'b00;
      1:       return 2'b10;
      2:       return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic settle();
    repeat (24) @(negedge clk);
  endtask

  task automatic move(input int d);
    logic [1:0] n;
    n = ab_of(pos_of(enc_a, enc_b) + d + 4);
    @(negedge clk);
    {enc_a, enc_b} = n;
    if (!cnt_clr) exp_cnt = exp_cnt + d;
    exp_raw = exp_raw + d;
    settle();
  endtask

  task automatic goto00();
    while (enc_a || enc_b) move(-1);
  endtask

  task automatic glitch(input logic on_b, input int w);
    @(negedge clk);
    if (on_b) enc_b = ~enc_b; else enc_a = ~enc_a;
    repeat (w) @(negedge clk);
    if (on_b) enc_b = ~enc_b; else enc_a = ~enc_a;
    settle();
  endtask

  // Step-mode pulse on A, width w clocks
  task automatic step_pulse(input int w);
    @(negedge clk);
    enc_a = 1'b1;
    repeat (w) @(negedge clk);
    enc_a = 1'b0;
    if (w >= thr_of(filt_long)) begin
      exp_cnt = exp_cnt + (enc_b ? 1 : -1);
      exp_raw = exp_raw + (enc_b ? 1 : -1);
    end
    settle();
  endtask

  task automatic set_idx(input logic v);
    @(negedge clk);
    enc_idx = v;
    settle();
  endtask

  task automatic rearm();
    @(negedge clk); idx_req = 1'b0;
    @(negedge clk); idx_req = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0042);
    rst_n = 1'b0;
    {enc_a, enc_b, enc_idx, enc_mask} = '0;
    filt_long = 1'b1; step_dir = 1'b0; idx_rise = 1'b1;
    mask_en = 1'b0; mask_low = 1'b0; cnt_clr = 1'b0; idx_req = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 count", count, 0);
    chk("R11 raw", raw, 0);
    chk("R11 armed", {31'd0, armed}, 0);
    chk("R11 err", {31'd0, qerr}, 0);

    // R3 forward and reverse
    repeat (4) move(1);
    chk("R3 forward count", count, exp_cnt);
    chk("R3 forward raw", raw, exp_raw);
    repeat (6) move(-1);
    chk("R3 reverse count", count, exp_cnt);
    chk("R3 reverse value", count, 32'hFFFF_FFFE);

    // R9 / R10 clear
    @(negedge clk); cnt_clr = 1'b1; exp_cnt = '0;
    repeat (3) @(negedge clk);
    chk("R9 clear held", count, 0);
    move(1);
    chk("R9 no count while clear", count, 0);
    chk("R10 raw ignores clear", raw, exp_raw);
    @(negedge clk); cnt_clr = 1'b0;
    goto00();
    chk("R3 after clear", count, exp_cnt);

    // R5 / R1 / R2 in step/dir mode
    @(negedge clk); step_dir = 1'b1;
    @(negedge clk); enc_b = 1'b1;
    settle();
    chk("R5 dir change alone", count, exp_cnt);
    filt_long = 1'b1;
    step_pulse(14);
    chk("R1 14-clock pulse rejected", count, exp_cnt);
    step_pulse(15);
    chk("R1 15-clock pulse accepted", count, exp_cnt);
    filt_long = 1'b0;
    step_pulse(2);
    chk("R2 2-clock pulse rejected", count, exp_cnt);
    step_pulse(3);
    chk("R2 3-clock pulse accepted", count, exp_cnt);
    @(negedge clk); enc_b = 1'b0;
    settle();
    step_pulse(20);
    chk("R5 down step", count, exp_cnt);
    chk("R5 raw", raw, exp_raw);
    @(negedge clk); step_dir = 1'b0;
    settle();

    // Random walk with glitches
    for (int i = 0; i < 300; i++) begin
      int act;
      filt_long = $urandom_range(0, 1);
      act = $urandom_range(0, 3);
      case (act)
        0: move(1);
        1: move(-1);
        2: glitch(1'b0, thr_of(filt_long) - 1);
        default: glitch(1'b1, thr_of(filt_long) - 1);
      endcase
      chk("R3 random count (R1/R2 glitches)", count, exp_cnt);
      chk("R10 random raw", raw, exp_raw);
    end
    filt_long = 1'b1;

    // R8 / R6 index
    repeat (3) move(1);
    rearm();
    chk("R8 armed after request", {31'd0, armed}, 1);
    set_idx(1'b1);
    exp_cnt = '0;
    chk("R6 rising clears", count, 0);
    chk("R8 ack dropped", {31'd0, armed}, 0);
    chk("R10 raw kept at index", raw, exp_raw);
    set_idx(1'b0);
    repeat (2) move(1);
    set_idx(1'b1);
    chk("R8 held request no rearm", count, exp_cnt);
    chk("R8 still disarmed", {31'd0, armed}, 0);
    set_idx(1'b0);
    idx_rise = 1'b0;
    rearm();
    set_idx(1'b1);
    chk("R6 rising ignored when falling selected", count, exp_cnt);
    chk("R6 still armed", {31'd0, armed}, 1);
    set_idx(1'b0);
    exp_cnt = '0;
    chk("R6 falling clears", count, 0);

    // R7 mask
    idx_rise = 1'b1; mask_en = 1'b1; mask_low = 1'b0;
    @(negedge clk); enc_mask = 1'b0;
    repeat (3) move(1);
    rearm();
    set_idx(1'b1);
    chk("R7 mask low blocks", count, exp_cnt);
    set_idx(1'b0);
    @(negedge clk); enc_mask = 1'b1;
    set_idx(1'b1);
    exp_cnt = '0;
    chk("R7 mask high passes", count, 0);
    set_idx(1'b0);
    mask_low = 1'b1;
    move(1);
    rearm();
    set_idx(1'b1);
    chk("R7 inverted mask blocks", count, exp_cnt);
    set_idx(1'b0);
    @(negedge clk); enc_mask = 1'b0;
    set_idx(1'b1);
    exp_cnt = '0;
    chk("R7 inverted mask passes", count, 0);
    chk("R10 raw after mask tests", raw, exp_raw);

    // R4 illegal transition
    goto00();
    chk("R4 no error yet", {31'd0, qerr}, 0);
    @(negedge clk); enc_a = 1'b1; enc_b = 1'b1;
    settle();
    chk("R4 double change ignored", count, exp_cnt);
    chk("R4 error set", {31'd0, qerr}, 1);
    move(1);
    chk("R4 counting resumes", count, exp_cnt);
    chk("R4 error sticky", {31'd0, qerr}, 1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule